// File: doc/BRIEF.md
# Timer Count-Source Selector with Overflow Flag

This block produces the count enable for an 8-bit timer and holds that timer. A three-bit source select picks what advances the counter. The counter can be held still, advanced on every system clock, or advanced on a tap of a free-running 10-bit prescaler. It can also follow a rising or a falling edge of an external pin. The pin is first brought into the system clock domain by a two-flop synchronizer and then passed through an edge detector. Each selected pin edge gives exactly one count.

Software can restart the prescaler by writing 1 to a strobe bit. The strobe clears itself in hardware and always reads back as zero. When the counter wraps from 255 to 0 it sets a sticky overflow flag. Writing 1 to the flag clears it. The interrupt line is the flag gated by a mask bit.

Top module: `tmr_clksel_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising clock edge), `count` is 0, `ovf_flag` is 0, `irq` is 0, `sel_rd` is 000, the mask is disabled and the prescaler is 0.
- R2: With select 000 the counter holds its value.
- R3: With select 001 the counter increments by one on every clock edge.
- R4: Selects 010, 011, 100 and 101 divide by 8, 64, 256 and 1024. The counter increments at an edge where the low 3, 6, 8 or 10 bits of the prescaler (the value before that edge) are all ones. The prescaler increments on every edge from reset.
- R5: A write with `psr_we` high and `psr_wdata` 1 clears the prescaler at that edge, so the next divide-by-8 count comes 8 edges later. A write of 0 has no effect. `psr_rd` always reads 0.
- R6: Select 111 counts rising edges and select 110 counts falling edges of `ext_pin`. A pin change made between edges shows in `count` after the third following rising clock edge.
- R7: A pin level held across at least one rising clock edge is counted. Pulses one clock period wide, repeated, each add one count.
- R8: On the edge where the counter wraps from 255 to 0, `ovf_flag` goes to 1 and stays set.
- R9: A write with `flag_clr_we` high and `flag_clr_wdata` 1 clears `ovf_flag`, and a write of 0 leaves it unchanged. A wrap in the same cycle wins and leaves the flag set.
- R10: `irq` is high exactly when `ovf_flag` is 1 and the mask bit, written through `mask_we`/`mask_wdata`, is 1.
- R11: `sel_rd` returns the last select value written with `sel_we`, and that value takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external count pin |
| sel_we | input | 1 | Source select write strobe |
| sel_wdata | input | 3 | Source select value |
| psr_we | input | 1 | Prescaler restart write strobe |
| psr_wdata | input | 1 | Prescaler restart data (1 restarts) |
| flag_clr_we | input | 1 | Overflow flag write strobe |
| flag_clr_wdata | input | 1 | Overflow flag write data (1 clears) |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 1 | Interrupt mask value |
| count | output | 8 | Counter value |
| sel_rd | output | 3 | Source select readback |
| psr_rd | output | 1 | Prescaler restart readback, always 0 |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked overflow interrupt |

## Verification
Random stimulus moves through all eight sources while the pin toggles at random intervals. A cycle-level reference model therefore compares every source against every tap and both edge polarities. Any wrong tap width or swapped edge shows as a count that drifts from the model. Directed runs cover three further cases. One measures the eight-edge spacing after a prescaler restart, which separates a restart from a write of 0. Another feeds one-period pin pulses to show that the synchronizer misses none. The last places a flag clear on the wrap edge to check that set wins over clear.

// File: rtl/tmr_sel_pkg.sv
package tmr_sel_pkg;
  typedef enum logic [2:0] {
    SRC_STOP     = 3'd0,
    SRC_DIV1     = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } src_sel_e;

  localparam int unsigned NUM_DIV = 5;

  // number of prescaler low bits that must be all ones for divider tap idx
  function automatic int unsigned div_log2(input int unsigned idx);
    case (idx)
      0:       div_log2 = 0;
      1:       div_log2 = 3;
      2:       div_log2 = 6;
      3:       div_log2 = 8;
      default: div_log2 = 10;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_sel_pkg::*;
#(
  parameter int unsigned PRE_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  output logic [NUM_DIV-1:0] taps
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clr) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
    localparam int unsigned K = div_log2(i);
    if (K == 0) begin : g_every
      assign taps[i] = 1'b1;
    end else begin : g_low
      assign taps[i] = &pre_q[K-1:0];
    end
  end

  // R5: a restart leaves the prescaler at zero
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_q == '0));
  // R4: a slower tap only fires when every faster tap fires
  a_r4_tap_nesting: assert property (@(posedge clk) disable iff (rst)
    taps[NUM_DIV-1] |-> taps[1]);
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int unsigned SH_W = STAGES + 1;
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SH_W-2:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

  // R6: one edge per transition, never both polarities at once
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
  // R7: a detected edge is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tmr_count8.sv
module tmr_count8 #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             flag_clr,
  input  logic             mask_we,
  input  logic             mask_wdata,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic mask_q;
  logic flag_d, mask_d, wrap;

  assign wrap = tick && (count == CNT_MAX);

  always_comb begin
    flag_d = ovf_flag;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      ovf_flag <= 1'b0;
      mask_q   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (tick) count <= count + 1'b1;
      ovf_flag <= flag_d;
      mask_q   <= mask_d;
      irq      <= flag_d & mask_d;
    end
  end

  // R8: the flag only rises on a wrap to zero
  a_r8_flag_on_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(count) == CNT_MAX) && (count == '0));
  // R10: the interrupt never fires without the flag
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovf_flag);
  // R2: without a tick the counter holds
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
endmodule

// File: rtl/tmr_clksel_top.sv
module tmr_clksel_top
  import tmr_sel_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRE_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pin,
  input  logic             sel_we,
  input  logic [2:0]       sel_wdata,
  input  logic             psr_we,
  input  logic             psr_wdata,
  input  logic             flag_clr_we,
  input  logic             flag_clr_wdata,
  input  logic             mask_we,
  input  logic             mask_wdata,
  output logic [CNT_W-1:0] count,
  output logic [2:0]       sel_rd,
  output logic             psr_rd,
  output logic             ovf_flag,
  output logic             irq
);
  src_sel_e           sel_q;
  logic [NUM_DIV-1:0] taps;
  logic               ext_rise, ext_fall;
  logic               tick;
  logic               pre_clr;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= SRC_STOP;
    else if (sel_we) sel_q <= src_sel_e'(sel_wdata);
  end

  assign pre_clr = psr_we & psr_wdata;
  assign sel_rd  = sel_q;
  assign psr_rd  = 1'b0;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .clr (pre_clr),
    .taps(taps)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (ext_pin),
    .rise(ext_rise),
    .fall(ext_fall)
  );

  always_comb begin
    case (sel_q)
      SRC_DIV1:     tick = taps[0];
      SRC_DIV8:     tick = taps[1];
      SRC_DIV64:    tick = taps[2];
      SRC_DIV256:   tick = taps[3];
      SRC_DIV1024:  tick = taps[4];
      SRC_EXT_FALL: tick = ext_fall;
      SRC_EXT_RISE: tick = ext_rise;
      default:      tick = 1'b0;
    endcase
  end

  tmr_count8 #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .flag_clr  (flag_clr_we & flag_clr_wdata),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .count     (count),
    .ovf_flag  (ovf_flag),
    .irq       (irq)
  );

  // R2: a stopped source freezes the counter at the port
  a_r2_stopped: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SRC_STOP) |=> $stable(count));
  // R3: divide-by-1 advances every edge
  a_r3_every_edge: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SRC_DIV1) |=> (count == $past(count) + 1'b1));
  // R11: a select write is visible on readback next cycle
  a_r11_sel_readback: assert property (@(posedge clk) disable iff (rst)
    sel_we |=> (sel_rd == $past(sel_wdata)));
endmodule

// File: tb/tmr_clksel_top_bench.sv
module tmr_clksel_top_bench;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pin = 1'b0;
  logic sel_we = 1'b0, psr_we = 1'b0, psr_wdata = 1'b0;
  logic flag_clr_we = 1'b0, flag_clr_wdata = 1'b0;
  logic mask_we = 1'b0, mask_wdata = 1'b0;
  logic [2:0] sel_wdata = 3'd0;
  logic [7:0] count;
  logic [2:0] sel_rd;
  logic psr_rd, ovf_flag, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [9:0] m_pre;
  logic [7:0] m_cnt;
  logic [2:0] m_sel;
  logic m_flag, m_mask, m_s1, m_s2, m_s3;

  always #(CLK_P/2) clk = ~clk;

  tmr_clksel_top u_tmr_clksel_top (
    .clk(clk), .rst(rst), .ext_pin(ext_pin),
    .sel_we(sel_we), .sel_wdata(sel_wdata),
    .psr_we(psr_we), .psr_wdata(psr_wdata),
    .flag_clr_we(flag_clr_we), .flag_clr_wdata(flag_clr_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .count(count), .sel_rd(sel_rd), .psr_rd(psr_rd),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  function automatic bit low_ones(input logic [9:0] p, input int k);
    logic [9:0] msk;
    msk = 10'((1 << k) - 1);
    return (p & msk) == msk;
  endfunction

  function automatic bit model_tick();
    case (m_sel)
      3'd1: return 1'b1;
      3'd2: return low_ones(m_pre, 3);
      3'd3: return low_ones(m_pre, 6);
      3'd4: return low_ones(m_pre, 8);
      3'd5: return low_ones(m_pre, 10);
      3'd6: return !m_s2 && m_s3;
      3'd7: return m_s2 && !m_s3;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cnt_tag(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6, 3'd7: return "R6";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre <= '0; m_cnt <= '0; m_sel <= '0; m_flag <= 0; m_mask <= 0;
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
    end else begin : upd
      bit t;
      t = model_tick();
      m_pre <= (psr_we && psr_wdata) ? 10'd0 : m_pre + 10'd1;
      if (t) m_cnt <= m_cnt + 8'd1;
      if (t && m_cnt == 8'hFF) m_flag <= 1'b1;
      else if (flag_clr_we && flag_clr_wdata) m_flag <= 1'b0;
      if (mask_we) m_mask <= mask_wdata;
      if (sel_we) m_sel <= sel_wdata;
      m_s1 <= ext_pin; m_s2 <= m_s1; m_s3 <= m_s2;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(cnt_tag(m_sel), "count", count, m_cnt);
    check("R8", "ovf_flag", ovf_flag, m_flag);
    check("R10", "irq", irq, m_flag & m_mask);
    check("R5", "psr_rd", psr_rd, 0);
    check("R11", "sel_rd", sel_rd, m_sel);
  endtask

  // set inputs for the next edge, then compare after it
  task automatic step(input logic sw, input logic [2:0] sd, input logic pw, input logic pd,
                      input logic cw, input logic cd, input logic mw, input logic md,
                      input logic pin);
    sel_we = sw; sel_wdata = sd; psr_we = pw; psr_wdata = pd;
    flag_clr_we = cw; flag_clr_wdata = cd; mask_we = mw; mask_wdata = md;
    ext_pin = pin;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, ext_pin);
  endtask

  task automatic set_sel(input logic [2:0] s);
    step(1, s, 0, 0, 0, 0, 0, 0, ext_pin);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "count", count, 0);
    check("R1", "ovf_flag", ovf_flag, 0);
    check("R1", "irq", irq, 0);
    check("R1", "sel_rd", sel_rd, 0);
    idle(5);
    check("R2", "count stopped", count, 0);

    // R5: restart then divide-by-8 spacing
    set_sel(3'd2);
    idle(20);
    step(0, 0, 1, 1, 0, 0, 0, 0, 0);
    c0 = count;
    idle(7);
    check("R5", "no count before 8 edges", count, c0);
    idle(1);
    check("R5", "count after 8 edges", count, 8'(c0 + 1));
    // R5: write of 0 does not restart
    idle(3);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle(40);

    // R7: one-period pulses on rising-edge source
    set_sel(3'd7);
    idle(4);
    c0 = count;
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 0, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    idle(4);
    check("R7", "pulses counted", count, 8'(c0 + 5));
    // R6: falling edges
    set_sel(3'd6);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle(4);
    c0 = count;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(1);
    check("R6", "no count at 2 edges", count, c0);
    idle(1);
    check("R6", "falling edge counted at 3rd edge", count, 8'(c0 + 1));

    // R9 / R10: wrap with clear in the same cycle, mask enabled
    step(0, 0, 0, 0, 0, 0, 1, 1, 0);
    set_sel(3'd1);
    while (m_cnt != 8'hFE) idle(1);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    check("R9", "set wins over clear", ovf_flag, 1);
    check("R10", "irq with mask", irq, 1);
    set_sel(3'd0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    check("R9", "clear write 0 ignored", ovf_flag, 1);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    check("R9", "clear write 1", ovf_flag, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic sw, pw, cw, mw, pin;
      sw = ($urandom % 64) == 0;
      pw = ($urandom % 50) == 0;
      cw = ($urandom % 40) == 0;
      mw = ($urandom % 30) == 0;
      pin = (($urandom % 3) == 0) ? ~ext_pin : ext_pin;
      step(sw, 3'($urandom), pw, 1'($urandom), cw, 1'($urandom), mw, 1'($urandom), pin);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule